// File: doc/BRIEF.md
# Completion Timeout Timer Bank

This block watches the non-posted requests a requester has in flight and raises an event when one of them is not answered in time. Every issued request is identified by a tag. Issuing a tag starts a per-tag timer whose length comes from the configured timeout range. A completion that carries the same tag stops that timer. If no completion arrives before the timer reaches its limit, the block reports the tag on a one-cycle timeout pulse and frees the tag.

Timers advance on a scaled timebase tick rather than on the core clock, so that windows of many seconds need only modest counters. The range selector offers a default window and eight programmable subranges, grouped into four bins. A build-time mask sets which bins the block supports. The same mask is reported on a capability output. A debug disable input stops all expiry. A completion whose tag is not outstanding changes nothing and is flagged on a one-cycle pulse, so that surrounding logic can count such events.

Top module: `cpl_timeout_bank`

## Requirements
- R1: After reset, no tag is outstanding, and `to_valid` and `unexp_cpl` are low.
- R2: `cap_ranges` equals the supported-bin mask: bit 0 covers selector codes 1 and 2, bit 1 covers 5 and 6, bit 2 covers 9 and 10, and bit 3 covers 13 and 14. The default mask is 4'b0011.
- R3: A tag issued with selector code 0 (default window, 1 ms), 1 (80 µs), 2 (5 ms), 5 (32 ms) or 6 (128 ms) times out after that time divided by `TICK_US` (10 µs by default), counted in ticks. With the defaults these are 100, 8, 500, 3200 and 12800 ticks. A tick counts when it is sampled high on a clock edge at which the tag is outstanding and the tag is not issued on that edge. `to_valid` rises one cycle after the edge that counts the last tick, stays high for one cycle, and carries the tag on `to_tag`.
- R4: A selector code that is reserved, or that belongs to a bin absent from the mask, uses the default window of 100 ticks.
- R5: A completion for an outstanding tag frees the tag, and no timeout is ever reported for that request.
- R6: A completion for a tag that is not outstanding raises `unexp_cpl` for the one cycle that follows. It has no effect on any timer.
- R7: While `cfg_disable` is high, timers do not advance and no timeout is reported. When the input falls, the timers resume from their held counts.
- R8: The window is latched when a tag is issued. A later change of `cfg_range` does not alter the windows of requests already outstanding.
- R9: When several tags are due in the same cycle, only one is reported per cycle, the lowest tag first. The others follow in later cycles.
- R10: Issuing a tag that is already outstanding restarts its timer from zero, using the window selected at that moment.
- R11: A completion that arrives in the cycle in which its tag has just become due wins, and no timeout is reported for that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick, one pulse every `TICK_US` microseconds |
| req_valid | input | 1 | A request is issued this cycle |
| req_tag | input | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | A completion is received this cycle |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cfg_range | input | 4 | Timeout range selector code |
| cfg_disable | input | 1 | Debug disable, stops all expiry |
| cap_ranges | output | 4 | Supported range bins |
| to_valid | output | 1 | One-cycle timeout event |
| to_tag | output | TAG_W | Tag that expired |
| unexp_cpl | output | 1 | One-cycle pulse for a completion that matches no outstanding tag |

## Verification
Corrupted per-tag state shows up only as a timeout event that is missing, early, late or carries the wrong tag. A wrong latched limit or count therefore stays hidden until the window of that tag ends, which can be thousands of cycles after the request was issued. A lost active flag shows up at once if a completion for that tag is then flagged as unexpected. The reference model predicts `to_valid`, `to_tag` and `unexp_cpl` on every cycle from the issue time, the window and the ticks seen. Any divergence is therefore reported in the first cycle in which the outputs differ.

// File: rtl/cto_pkg.sv
package cto_pkg;
   localparam int unsigned SEL_W      = 4;
   localparam int unsigned NUM_BINS   = 4;
   localparam int unsigned DEFAULT_US = 1000;
   localparam int unsigned LONGEST_US = 32_000_000;

   // window length in microseconds for each programmable code, 0 when reserved
   function automatic int unsigned sel_us(input logic [SEL_W-1:0] sel);
      case (sel)
         4'd1:    return 80;
         4'd2:    return 5_000;
         4'd5:    return 32_000;
         4'd6:    return 128_000;
         4'd9:    return 512_000;
         4'd10:   return 2_000_000;
         4'd13:   return 8_000_000;
         4'd14:   return 32_000_000;
         default: return 0;
      endcase
   endfunction

   // {valid, bin index} of a selector code
   function automatic logic [2:0] bin_of(input logic [SEL_W-1:0] sel);
      case (sel)
         4'd1, 4'd2:   return 3'b100;
         4'd5, 4'd6:   return 3'b101;
         4'd9, 4'd10:  return 3'b110;
         4'd13, 4'd14: return 3'b111;
         default:      return 3'b000;
      endcase
   endfunction

   function automatic int unsigned to_ticks(input int unsigned us, input int unsigned tick_us);
      int unsigned t;
      t = us / tick_us;
      return (t == 0) ? 1 : t;
   endfunction
endpackage

// File: rtl/cto_range_decode.sv
module cto_range_decode
   import cto_pkg::*;
#(
   parameter int unsigned TICK_US = 10,
   parameter logic [NUM_BINS-1:0] SUPPORT = 4'b0011,
   parameter int unsigned CNT_W = 22
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] limit
);
   localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(to_ticks(DEFAULT_US, TICK_US));

   generate
      if (SUPPORT == '0) begin : g_fixed
         logic unused_sel;
         assign unused_sel = ^sel;
         assign limit      = DEF_LIM;
      end else begin : g_prog
         logic [2:0] bin;
         always_comb begin
            bin = bin_of(sel);
            if (bin[2] && SUPPORT[bin[1:0]])
               limit = CNT_W'(to_ticks(sel_us(sel), TICK_US));
            else
               limit = DEF_LIM;
         end
      end
   endgenerate
endmodule

// File: rtl/cto_tag_timer.sv
module cto_tag_timer #(
   parameter int unsigned CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             active_o,
   output logic             due_o
);
   logic             act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         lim_q <= '0;
      end else if (start_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
         lim_q <= limit_i;
      end else if (stop_i) begin
         act_q <= 1'b0;
      end else if (act_q && tick_i && (cnt_q != lim_q)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign active_o = act_q;
   assign due_o    = act_q && (cnt_q == lim_q);
endmodule

// File: rtl/cto_expiry_arb.sv
module cto_expiry_arb #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     grant_o
);
   always_comb begin
      any_o   = 1'b0;
      idx_o   = '0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !any_o) begin
            any_o      = 1'b1;
            idx_o      = IDX_W'(i);
            grant_o[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cpl_timeout_bank.sv
module cpl_timeout_bank
   import cto_pkg::*;
#(
   parameter int unsigned NUM_TAGS = 8,
   parameter int unsigned TAG_W    = $clog2(NUM_TAGS),
   parameter int unsigned TICK_US  = 10,
   parameter logic [NUM_BINS-1:0] SUPPORT = 4'b0011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             req_valid,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             cpl_valid,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic [SEL_W-1:0] cfg_range,
   input  logic             cfg_disable,
   output logic [NUM_BINS-1:0] cap_ranges,
   output logic             to_valid,
   output logic [TAG_W-1:0] to_tag,
   output logic             unexp_cpl
);
   localparam int unsigned MAX_TICKS = to_ticks(LONGEST_US, TICK_US);
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   generate
      if (NUM_TAGS < 2) begin : g_bad_tags
         $error("NUM_TAGS must be at least 2");
      end
      if (TAG_W != $clog2(NUM_TAGS)) begin : g_bad_tagw
         $error("TAG_W must equal clog2(NUM_TAGS)");
      end
      if (TICK_US == 0 || TICK_US > 40) begin : g_bad_tick
         $error("TICK_US must lie in 1..40 so the shortest window spans two ticks");
      end
   endgenerate

   logic [CNT_W-1:0]    new_limit;
   logic [NUM_TAGS-1:0] start_v, hit_v, active_v, due_v, elig_v, grant_v;
   logic                tick_run;
   logic                exp_any;
   logic [TAG_W-1:0]    exp_idx;
   logic                to_valid_q, unexp_q;
   logic [TAG_W-1:0]    to_tag_q;

   assign tick_run   = tick && !cfg_disable;
   assign cap_ranges = SUPPORT;

   cto_range_decode #(
      .TICK_US (TICK_US),
      .SUPPORT (SUPPORT),
      .CNT_W   (CNT_W)
   ) u_dec (
      .sel   (cfg_range),
      .limit (new_limit)
   );

   generate
      for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
         assign start_v[g] = req_valid && (req_tag == TAG_W'(g));
         assign hit_v[g]   = cpl_valid && (cpl_tag == TAG_W'(g));

         cto_tag_timer #(
            .CNT_W (CNT_W)
         ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start_v[g]),
            .stop_i   (hit_v[g] | grant_v[g]),
            .tick_i   (tick_run),
            .limit_i  (new_limit),
            .active_o (active_v[g]),
            .due_o    (due_v[g])
         );
      end
   endgenerate

   // due tags compete unless a completion or a fresh issue claims them this cycle
   assign elig_v = due_v & ~hit_v & ~start_v & {NUM_TAGS{~cfg_disable}};

   cto_expiry_arb #(
      .N     (NUM_TAGS),
      .IDX_W (TAG_W)
   ) u_arb (
      .req_i   (elig_v),
      .any_o   (exp_any),
      .idx_o   (exp_idx),
      .grant_o (grant_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_valid_q <= 1'b0;
         to_tag_q   <= '0;
         unexp_q    <= 1'b0;
      end else begin
         to_valid_q <= exp_any;
         to_tag_q   <= exp_any ? exp_idx : to_tag_q;
         unexp_q    <= cpl_valid && ~|(hit_v & active_v);
      end
   end

   assign to_valid  = to_valid_q;
   assign to_tag    = to_tag_q;
   assign unexp_cpl = unexp_q;
endmodule

// File: rtl/cpl_timeout_bank_chk.sv
module cpl_timeout_bank_chk #(
   parameter int unsigned TAG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [TAG_W-1:0] req_tag,
   input logic             cpl_valid,
   input logic [TAG_W-1:0] cpl_tag,
   input logic             cfg_disable,
   input logic             to_valid,
   input logic [TAG_W-1:0] to_tag,
   input logic             unexp_cpl
);
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!to_valid && !unexp_cpl));

   assert_disable_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_disable |=> !to_valid);

   assert_unexp_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unexp_cpl |-> $past(cpl_valid));

   assert_cpl_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      to_valid |-> !($past(cpl_valid) && ($past(cpl_tag) == to_tag)));

   assert_reissue_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      to_valid |-> !($past(req_valid) && ($past(req_tag) == to_tag)));

   assert_single_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (to_valid && $past(to_valid)) |-> (to_tag != $past(to_tag)));
endmodule

bind cpl_timeout_bank cpl_timeout_bank_chk #(.TAG_W(TAG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_tag     (req_tag),
   .cpl_valid   (cpl_valid),
   .cpl_tag     (cpl_tag),
   .cfg_disable (cfg_disable),
   .to_valid    (to_valid),
   .to_tag      (to_tag),
   .unexp_cpl   (unexp_cpl)
);

// File: tb/cpl_timeout_bank_tb.sv
`timescale 1ns/1ps
module cpl_timeout_bank_tb;
   localparam int N  = 8;
   localparam int TW = 3;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic req_valid = 1'b0, cpl_valid = 1'b0, cfg_disable = 1'b0;
   logic [TW-1:0] req_tag = '0, cpl_tag = '0;
   logic [3:0] cfg_range = '0;
   logic [3:0] cap_ranges;
   logic to_valid, unexp_cpl;
   logic [TW-1:0] to_tag;

   always #2 clk = ~clk;

   cpl_timeout_bank u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req_valid(req_valid), .req_tag(req_tag),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
      .cfg_range(cfg_range), .cfg_disable(cfg_disable),
      .cap_ranges(cap_ranges), .to_valid(to_valid), .to_tag(to_tag),
      .unexp_cpl(unexp_cpl)
   );

   int n_checks = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // timebase tick: high one cycle in every tick_div while enabled
   int tick_div = 1, tick_ph = 0;
   bit tick_on = 1;
   always @(negedge clk) begin
      if (tick_on) begin
         tick    = (tick_ph == 0);
         tick_ph = (tick_ph + 1) % tick_div;
      end else begin
         tick = 1'b0;
      end
   end

   // reference model
   function automatic int ref_limit(input logic [3:0] c);
      case (c)
         4'd1:    return 8;
         4'd2:    return 500;
         4'd5:    return 3200;
         4'd6:    return 12800;
         default: return 100;
      endcase
   endfunction

   bit m_act[N];
   int m_cnt[N], m_lim[N];
   bit e_tov = 0, e_unexp = 0;
   int e_tag = 0, pick = -1;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < N; t++) begin m_act[t] = 0; m_cnt[t] = 0; m_lim[t] = 0; end
         e_tov = 0; e_unexp = 0; e_tag = 0;
      end else begin
         pick = -1;
         for (int t = 0; t < N; t++)
            if (pick < 0 && m_act[t] && m_cnt[t] == m_lim[t] && !cfg_disable
                && !(cpl_valid && cpl_tag == t) && !(req_valid && req_tag == t))
               pick = t;
         e_unexp = cpl_valid && !m_act[cpl_tag];
         e_tov   = (pick >= 0);
         if (pick >= 0) e_tag = pick;
         for (int t = 0; t < N; t++) begin
            if (req_valid && req_tag == t) begin
               m_act[t] = 1; m_cnt[t] = 0; m_lim[t] = ref_limit(cfg_range);
            end else if (pick == t || (cpl_valid && cpl_tag == t)) begin
               m_act[t] = 0;
            end else if (m_act[t] && tick && !cfg_disable && m_cnt[t] < m_lim[t]) begin
               m_cnt[t]++;
            end
         end
      end
   end

   int seen[N];
   int unexp_seen = 0;
   initial for (int t = 0; t < N; t++) seen[t] = 0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(to_valid == e_tov, cur_req, "to_valid", to_valid, e_tov);
         if (e_tov && to_valid) check(to_tag == e_tag, cur_req, "to_tag", to_tag, e_tag);
         check(unexp_cpl == e_unexp, cur_req, "unexp_cpl", unexp_cpl, e_unexp);
         if (to_valid) seen[to_tag]++;
         if (unexp_cpl) unexp_seen++;
      end
   end

   task automatic summary();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         summary();
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input int tag, input int code);
      req_valid = 1'b1; req_tag = TW'(tag); cfg_range = 4'(code);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic complete(input int tag);
      cpl_valid = 1'b1; cpl_tag = TW'(tag);
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   int s0, s1, s2, s3, s4, s5, u0;

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R2 capability mask
      check(to_valid == 1'b0, "R1", "to_valid after reset", to_valid, 0);
      check(unexp_cpl == 1'b0, "R1", "unexp_cpl after reset", unexp_cpl, 0);
      check(cap_ranges == 4'b0011, "R2", "cap_ranges", cap_ranges, 3);

      // R3 default window
      cur_req = "R3";
      s0 = seen[0];
      issue(0, 0); idle(110);
      check(seen[0] == s0 + 1, "R3", "default window timeouts", seen[0], s0 + 1);

      // R3 two programmable codes at once
      s1 = seen[1]; s2 = seen[2];
      issue(1, 1); issue(2, 2); idle(520);
      check(seen[1] == s1 + 1, "R3", "code1 timeouts", seen[1], s1 + 1);
      check(seen[2] == s2 + 1, "R3", "code2 timeouts", seen[2], s2 + 1);

      s3 = seen[3];
      issue(3, 5); idle(3300);
      check(seen[3] == s3 + 1, "R3", "code5 timeouts", seen[3], s3 + 1);

      // R4 unsupported bin and reserved code fall back to default
      cur_req = "R4";
      s4 = seen[4]; s5 = seen[5];
      issue(4, 9); issue(5, 3); idle(110);
      check(seen[4] == s4 + 1, "R4", "unsupported code timeouts", seen[4], s4 + 1);
      check(seen[5] == s5 + 1, "R4", "reserved code timeouts", seen[5], s5 + 1);

      // R5 completion stops the timer
      cur_req = "R5";
      s0 = seen[6];
      issue(6, 2); idle(50); complete(6); idle(520);
      check(seen[6] == s0, "R5", "completed tag timeouts", seen[6], s0);

      // R6 unexpected completion
      cur_req = "R6";
      u0 = unexp_seen; s0 = seen[7];
      complete(7); idle(3);
      check(unexp_seen == u0 + 1, "R6", "unexpected pulses", unexp_seen, u0 + 1);
      check(seen[7] == s0, "R6", "no timeout from stray completion", seen[7], s0);

      // R7 disable freezes and suppresses
      cur_req = "R7";
      s0 = seen[0];
      issue(0, 1); cfg_disable = 1'b1; idle(40);
      check(seen[0] == s0, "R7", "timeouts while disabled", seen[0], s0);
      cfg_disable = 1'b0; idle(20);
      check(seen[0] == s0 + 1, "R7", "timeouts after enable", seen[0], s0 + 1);

      // R8 window latched at issue
      cur_req = "R8";
      s1 = seen[1]; s2 = seen[2];
      issue(1, 1); cfg_range = 4'd2; idle(12);
      check(seen[1] == s1 + 1, "R8", "early window kept", seen[1], s1 + 1);
      issue(2, 2); cfg_range = 4'd1; idle(12);
      check(seen[2] == s2, "R8", "long window kept", seen[2], s2);
      idle(500);
      check(seen[2] == s2 + 1, "R8", "long window expiry", seen[2], s2 + 1);

      // R9 simultaneous expiry, lowest tag first
      cur_req = "R9";
      s3 = seen[3]; s4 = seen[4]; s5 = seen[5];
      tick_on = 0;
      issue(5, 1); issue(3, 1); issue(4, 1);
      tick_on = 1; idle(15);
      check(seen[3] == s3 + 1, "R9", "tag3 reported", seen[3], s3 + 1);
      check(seen[4] == s4 + 1, "R9", "tag4 reported", seen[4], s4 + 1);
      check(seen[5] == s5 + 1, "R9", "tag5 reported", seen[5], s5 + 1);

      // R10 reissue restarts
      cur_req = "R10";
      s0 = seen[6];
      issue(6, 1); idle(5); issue(6, 1); idle(5);
      check(seen[6] == s0, "R10", "no expiry after restart", seen[6], s0);
      idle(6);
      check(seen[6] == s0 + 1, "R10", "expiry after restart", seen[6], s0 + 1);

      // R11 completion in the due cycle wins
      cur_req = "R11";
      s0 = seen[7];
      issue(7, 1); idle(8); complete(7); idle(5);
      check(seen[7] == s0, "R11", "completion at due cycle", seen[7], s0);

      // R3 with sparse ticks
      cur_req = "R3";
      tick_div = 3; tick_ph = 0;
      s0 = seen[0];
      issue(0, 1); idle(30);
      check(seen[0] == s0 + 1, "R3", "sparse tick expiry", seen[0], s0 + 1);

      idle(2);
      summary();
      $finish;
   end
endmodule